// File: doc/BRIEF.md
# Serial Control Register Port

This block receives write-only control words for a stereo audio converter over a three-wire serial link. A control clock carries one bit per rising edge, most significant bit first. A separate latch line commits the word with a rising edge. The control clock may be gated, so it can stop between bits or between words. All three serial lines are brought into the system clock domain through two-flop synchronizers, and rising edges are found there. The serial lines must therefore hold each level for at least three system clock cycles.

Each word is 16 bits wide. The top two bits name the destination and the low fourteen bits carry the value. A word can set the left attenuation level or the right attenuation level. A word sent to the mode register sets the two per-channel mute bits and the de-emphasis curve select. If a latch edge arrives before a whole word has been shifted in, the partial word is dropped. Every latch edge starts a new word.

Top module: `ctl_serial_port`

## Requirements
- R1: While `rst_n` is sampled low on a system clock edge, every register returns to its default: both attenuation outputs are 14'h3FFF (full scale, no attenuation), both mute outputs are 0, `deemph_sel` is 2'b00 (44.1 kHz curve), and the bit count is cleared.
- R2: A committed word whose bits [15:14] are 2'b00 loads bits [13:0] into `vol_left`, with the first bit shifted in landing in bit 15.
- R3: A committed word whose bits [15:14] are 2'b01 loads bits [13:0] into `vol_right` and leaves `vol_left` unchanged.
- R4: A committed word whose bits [15:14] are 2'b10 sets `deemph_sel` from bits [1:0] (00 = 44.1 kHz, 01 = 32 kHz, 10 = 48 kHz, 11 is stored as written), `mute_left` from bit 2 and `mute_right` from bit 3. Bits [13:4] are ignored.
- R5: A committed word whose bits [15:14] are 2'b11 changes no output.
- R6: If fewer than 16 bits have been shifted in when the latch rises, the word is discarded and all outputs keep their values. The bit count restarts at zero, so the next full word commits normally.
- R7: If more than 16 bits arrive before the latch rises, the last 16 bits shifted in form the word.
- R8: Outputs change only after a latch rising edge. Shifting bits in without a latch leaves every output unchanged.
- R9: Bits may be spaced by arbitrary idle gaps in the control clock, and the gaps may differ from bit to bit. The captured word does not depend on the gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Control clock, may be gated; data sampled on its rising edge |
| ser_dat | input | 1 | Serial control data, MSB first |
| ser_latch | input | 1 | Commit strobe, rising-edge sensitive |
| vol_left | output | 14 | Left channel attenuation level |
| vol_right | output | 14 | Right channel attenuation level |
| mute_left | output | 1 | Left channel mute |
| mute_right | output | 1 | Right channel mute |
| deemph_sel | output | 2 | De-emphasis curve select |

## Verification
Words are sent to each of the four destinations using bit patterns that alternate and are asymmetric. A reversed bit order or a swapped channel would show up as a wrong value. Short and long bursts check how the bit count bounds a word: a discarded word leaves old values in place, and an overlong one keeps only its tail. A burst without a latch shows that shifting alone commits nothing. Sending the same value with uneven gaps between control clock pulses shows that the gated clock is handled correctly. A reset in the middle of a word checks both the defaults and a clean restart.

// File: rtl/ctl_pkg.sv
// Package: shared widths, destination codes and reset defaults for the
// serial control register port. Assumes one fixed 16-bit word format.
package ctl_pkg;
    localparam int WORD_W = 16;
    localparam int DEST_W = 2;
    localparam int VAL_W  = WORD_W - DEST_W;
    localparam int CNT_W  = $clog2(WORD_W + 1);

    typedef enum logic [DEST_W-1:0] {
        DEST_LEFT  = 2'b00,
        DEST_RIGHT = 2'b01,
        DEST_MODE  = 2'b10,
        DEST_NONE  = 2'b11
    } dest_e;

    // Mode register bit positions inside the value field
    localparam int MODE_DE_LSB  = 0;
    localparam int MODE_MUTE_L  = 2;
    localparam int MODE_MUTE_R  = 3;

    localparam logic [VAL_W-1:0] VOL_DEFAULT    = '1;
    localparam logic [1:0]       DEEMPH_DEFAULT = 2'b00;
endpackage

// File: rtl/ctl_sync.sv
// Module: multi-bit two-flop synchronizer. Each bit is treated as an
// independent asynchronous level; the caller keeps levels stable long enough.
module ctl_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] level
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Two flops per bit, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_in;
            stab_q <= meta_q;
        end
    end

    assign level = stab_q;
endmodule

// File: rtl/ctl_edge.sv
// Module: rising-edge detector for synchronized levels; one pulse per bit
// lasting one system clock. Assumes inputs are already synchronous.
module ctl_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    // Remember the previous level of each bit
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    for (genvar i = 0; i < W; i++) begin : g_edge
        assign rise[i] = level[i] & ~prev_q[i];
    end
endmodule

// File: rtl/ctl_shift.sv
// Module: MSB-first shift register with a saturating bit counter. A clear
// restarts the count; the word is only valid once the count is full.
module ctl_shift
    import ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic              clear,
    output logic [WORD_W-1:0] word,
    output logic              full
);
    logic [WORD_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;

    // Shift in new bits at the bottom so the first bit ends at the top
    always_ff @(posedge clk) begin
        if (!rst_n)        sh_q <= '0;
        else if (shift_en) sh_q <= {sh_q[WORD_W-2:0], bit_in};
    end

    // Count bits since the last latch, stopping at a full word
    always_ff @(posedge clk) begin
        if (!rst_n || clear)
            cnt_q <= '0;
        else if (shift_en && cnt_q != CNT_W'(WORD_W))
            cnt_q <= cnt_q + 1'b1;
    end

    assign word = sh_q;
    assign full = (cnt_q == CNT_W'(WORD_W));
endmodule

// File: rtl/ctl_regfile.sv
// Module: decodes a committed word and updates the addressed register.
// Assumes commit is a single-cycle pulse qualified by a full word.
module ctl_regfile
    import ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [WORD_W-1:0] word,
    output logic [VAL_W-1:0]  vol_left,
    output logic [VAL_W-1:0]  vol_right,
    output logic              mute_left,
    output logic              mute_right,
    output logic [1:0]        deemph_sel
);
    dest_e            dest;
    logic [VAL_W-1:0] value;

    assign dest  = dest_e'(word[WORD_W-1 -: DEST_W]);
    assign value = word[VAL_W-1:0];

    // Left attenuation register
    always_ff @(posedge clk) begin
        if (!rst_n)                             vol_left <= VOL_DEFAULT;
        else if (commit && dest == DEST_LEFT)   vol_left <= value;
    end

    // Right attenuation register
    always_ff @(posedge clk) begin
        if (!rst_n)                             vol_right <= VOL_DEFAULT;
        else if (commit && dest == DEST_RIGHT)  vol_right <= value;
    end

    // Mode register: mutes and de-emphasis curve
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mute_left  <= 1'b0;
            mute_right <= 1'b0;
            deemph_sel <= DEEMPH_DEFAULT;
        end else if (commit && dest == DEST_MODE) begin
            mute_left  <= value[MODE_MUTE_L];
            mute_right <= value[MODE_MUTE_R];
            deemph_sel <= value[MODE_DE_LSB +: 2];
        end
    end
endmodule

// File: rtl/ctl_serial_port.sv
// Module: top of the serial control register port. Synchronizes the three
// serial lines, shifts bits on control clock edges and commits full words
// on latch edges. Assumes serial levels last at least three system clocks.
module ctl_serial_port
    import ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_latch,
    output logic [VAL_W-1:0] vol_left,
    output logic [VAL_W-1:0] vol_right,
    output logic             mute_left,
    output logic             mute_right,
    output logic [1:0]       deemph_sel
);
    localparam int SYNC_W = 3;
    localparam int EDGE_W = 2;

    logic [SYNC_W-1:0] lvl;
    logic [EDGE_W-1:0] rise;
    logic              clk_rise;
    logic              latch_rise;
    logic [WORD_W-1:0] word;
    logic              word_full;

    ctl_sync #(.W(SYNC_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_dat, ser_latch, ser_clk}),
        .level    (lvl)
    );

    ctl_edge #(.W(EDGE_W)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (lvl[EDGE_W-1:0]),
        .rise  (rise)
    );

    assign clk_rise   = rise[0];
    assign latch_rise = rise[1];

    ctl_shift u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (clk_rise),
        .bit_in   (lvl[2]),
        .clear    (latch_rise),
        .word     (word),
        .full     (word_full)
    );

    ctl_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (latch_rise && word_full),
        .word       (word),
        .vol_left   (vol_left),
        .vol_right  (vol_right),
        .mute_left  (mute_left),
        .mute_right (mute_right),
        .deemph_sel (deemph_sel)
    );
endmodule

// File: rtl/ctl_serial_port_chk.sv
// Module: assertion checker bound to the top; observes ports and the
// internal edge pulses and word state without driving anything.
module ctl_serial_port_chk
    import ctl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              latch_rise,
    input logic              word_full,
    input logic [WORD_W-1:0] word,
    input logic [VAL_W-1:0]  vol_left,
    input logic [VAL_W-1:0]  vol_right,
    input logic              mute_left,
    input logic              mute_right,
    input logic [1:0]        deemph_sel
);
    assert_defaults_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (vol_left == VOL_DEFAULT && vol_right == VOL_DEFAULT
                          && !mute_left && !mute_right && deemph_sel == DEEMPH_DEFAULT));

    assert_left_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_rise && word_full && word[WORD_W-1 -: DEST_W] == 2'b00)
        |=> vol_left == $past(word[VAL_W-1:0]));

    assert_right_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_rise && word_full && word[WORD_W-1 -: DEST_W] == 2'b01)
        |=> (vol_right == $past(word[VAL_W-1:0]) && $stable(vol_left)));

    assert_short_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_rise && !word_full)
        |=> ($stable(vol_left) && $stable(vol_right) && $stable(mute_left)
             && $stable(mute_right) && $stable(deemph_sel)));

    assert_no_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_rise
        |=> ($stable(vol_left) && $stable(vol_right) && $stable(mute_left)
             && $stable(mute_right) && $stable(deemph_sel)));
endmodule

bind ctl_serial_port ctl_serial_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .latch_rise (latch_rise),
    .word_full  (word_full),
    .word       (word),
    .vol_left   (vol_left),
    .vol_right  (vol_right),
    .mute_left  (mute_left),
    .mute_right (mute_right),
    .deemph_sel (deemph_sel)
);

// File: tb/ctl_serial_port_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module ctl_serial_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_dat = 1'b0;
    logic        ser_latch = 1'b0;
    logic [13:0] vol_left, vol_right;
    logic        mute_left, mute_right;
    logic [1:0]  deemph_sel;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_serial_port u_ctl_serial_port (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_latch(ser_latch), .vol_left(vol_left), .vol_right(vol_right),
        .mute_left(mute_left), .mute_right(mute_right), .deemph_sel(deemph_sel)
    );

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send_bits(input logic [31:0] bits, input int n, input int gap);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = bits[i];
            wait_clks(HOLD);
            ser_clk = 1'b1;
            wait_clks(HOLD);
            ser_clk = 1'b0;
            wait_clks(gap + (i % 3) * gap);
        end
    endtask

    task automatic latch();
        ser_latch = 1'b1;
        wait_clks(HOLD);
        ser_latch = 1'b0;
        wait_clks(HOLD + 2);
    endtask

    task automatic send_word(input logic [15:0] w);
        send_bits({16'h0, w}, 16, 1);
        latch();
    endtask

    task automatic check_all(input string req, input logic [13:0] vl,
                             input logic [13:0] vr, input logic ml,
                             input logic mr, input logic [1:0] de);
        check(req, "vol_left",   {2'b0, vol_left},   {2'b0, vl});
        check(req, "vol_right",  {2'b0, vol_right},  {2'b0, vr});
        check(req, "mute_left",  {15'b0, mute_left}, {15'b0, ml});
        check(req, "mute_right", {15'b0, mute_right},{15'b0, mr});
        check(req, "deemph_sel", {14'b0, deemph_sel},{14'b0, de});
    endtask

    task automatic t_reset_R1();
        rst_n = 1'b0;
        wait_clks(3);
        rst_n = 1'b1;
        wait_clks(1);
        check_all("R1", 14'h3FFF, 14'h3FFF, 1'b0, 1'b0, 2'b00);
    endtask

    task automatic t_left_R2();
        send_word({2'b00, 14'h2A5C});
        check_all("R2", 14'h2A5C, 14'h3FFF, 1'b0, 1'b0, 2'b00);
    endtask

    task automatic t_right_R3();
        send_word({2'b01, 14'h0193});
        check_all("R3", 14'h2A5C, 14'h0193, 1'b0, 1'b0, 2'b00);
    endtask

    task automatic t_mode_R4();
        send_word({2'b10, 10'h3FF, 4'b0101});
        check_all("R4", 14'h2A5C, 14'h0193, 1'b1, 1'b0, 2'b01);
        send_word({2'b10, 10'h000, 4'b1010});
        check_all("R4", 14'h2A5C, 14'h0193, 1'b0, 1'b1, 2'b10);
    endtask

    task automatic t_reserved_R5();
        send_word({2'b11, 14'h1234});
        check_all("R5", 14'h2A5C, 14'h0193, 1'b0, 1'b1, 2'b10);
    endtask

    task automatic t_short_R6();
        send_bits({16'h0, 2'b00, 14'h0001}, 10, 1);
        latch();
        check_all("R6", 14'h2A5C, 14'h0193, 1'b0, 1'b1, 2'b10);
        send_word({2'b00, 14'h0777});
        check("R6", "vol_left after restart", {2'b0, vol_left}, 16'h0777);
    endtask

    task automatic t_long_R7();
        send_bits({12'h0, 4'b1111, 2'b01, 14'h1C3E}, 20, 1);
        latch();
        check("R7", "vol_right", {2'b0, vol_right}, 16'h1C3E);
        check("R7", "vol_left",  {2'b0, vol_left},  16'h0777);
    endtask

    task automatic t_no_latch_R8();
        send_bits({16'h0, 2'b00, 14'h0055}, 16, 1);
        wait_clks(20);
        check("R8", "vol_left held", {2'b0, vol_left}, 16'h0777);
        latch();
        check("R8", "vol_left after latch", {2'b0, vol_left}, 16'h0055);
    endtask

    task automatic t_gated_R9();
        send_bits({16'h0, 2'b01, 14'h2D4B}, 16, 9);
        latch();
        check("R9", "vol_right", {2'b0, vol_right}, 16'h2D4B);
    endtask

    task automatic t_midword_reset_R1();
        send_bits({16'h0, 2'b00, 14'h0F0F}, 7, 1);
        t_reset_R1();
        send_word({2'b00, 14'h3210});
        check("R1", "word after mid-word reset", {2'b0, vol_left}, 16'h3210);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_R1();
        t_left_R2();
        t_right_R3();
        t_mode_R4();
        t_reserved_R5();
        t_short_R6();
        t_long_R7();
        t_no_latch_R8();
        t_gated_R9();
        t_midword_reset_R1();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule